// File: doc/BRIEF.md
# Mirrored Channel Failover Controller

This block connects one memory request port to two memory channels that hold the same data. Each write is sent to both channels, so the address space seen upstream is the size of a single channel. Reads normally go to channel 0. Every read beat a channel returns carries two flags, one for a correctable error and one for an uncorrectable error. When the channel being read returns an uncorrectable error while both copies are still healthy, the block issues the same read to the partner channel and returns the partner's data, marked as correctable.

After such a recovery the failed channel is retired until reset. From then on, reads and writes go only to the surviving copy, and a write completes once that copy alone has accepted it. The recovery also raises a single-cycle failover event that an event log can capture. A sticky status output reports whether the pair is degraded and which channel failed.

The block also counts correctable read responses for each rank, where the rank is the top address bits. It flags the first correctable response seen on each rank and pulses once when a rank's count reaches a programmable threshold.

Top module: `mirror_failover`

## Requirements
- R1: While healthy, a write is presented to both channels, and the write acknowledge (`rsp_valid_o` with `rsp_write_o`=1) appears only after both channels have accepted it (valid and ready high on the same edge).
- R2: While healthy, a read is sent only to channel 0, and that channel's data and flags are returned: ce=1 when the beat has ce=1 and ue=0, and ue=1 when the beat has ue=1.
- R3: While healthy, an uncorrectable error from channel 0 leads to a re-read of the same address from channel 1. If that beat is clean, its data is returned with `rsp_ce_o`=1 and `rsp_ue_o`=0.
- R4: A recovery as in R3 sets `degraded_o`=1 and `failed_ch_o` to the failed channel (0) on the same edge as the response. Both hold until reset.
- R5: `failover_evt_o` is high for exactly the cycle in which the recovered response is valid, and it fires only for the first failover.
- R6: Once degraded, the failed channel never sees a request, reads and writes go to the survivor, and a write is acknowledged on the survivor's acceptance alone.
- R7: While healthy, if both channels return an uncorrectable error for a read, the response has ue=1 and ce=0, and no failover takes place.
- R8: Once degraded, an uncorrectable error from the survivor is returned with ue=1 and ce=0, and no new event is raised.
- R9: Each rank has its own counter, where the rank is the top RANK_BITS address bits. The counter increments by one on each read response with ce=1 (recovered responses included) and saturates at its all-ones value. Counts appear on `ce_cnt_o`, with rank r in bits [r*CW +: CW], one cycle after the response.
- R10: `ce_first_o` pulses for one cycle, one cycle after the first correctable response of a rank since reset, and `ce_rank_o` gives that rank.
- R11: `ce_thresh_o` pulses once, one cycle after the response that brings a rank's count to at least `ce_thresh_i`. It does not pulse again for that rank until `ce_clr_i[rank]` has been asserted.
- R12: After reset, `req_ready_o`=1, `rsp_valid_o`=0, `degraded_o`=0, `failover_evt_o`=0 and all counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Upstream request valid |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Response or write acknowledge, one cycle |
| rsp_write_o | output | 1 | Response belongs to a write |
| rsp_rdata_o | output | DW | Read data |
| rsp_ce_o | output | 1 | Correctable (or recovered) error |
| rsp_ue_o | output | 1 | Uncorrectable error |
| ch_valid_o | output | 2 | Per-channel request valid |
| ch_ready_i | input | 2 | Per-channel request accept |
| ch_write_o | output | 1 | Channel request is a write |
| ch_addr_o | output | AW | Channel address |
| ch_wdata_o | output | DW | Channel write data |
| ch_rsp_valid_i | input | 2 | Per-channel read beat valid |
| ch_rdata_i | input | 2*DW | Read data, channel c in [c*DW +: DW] |
| ch_ce_i | input | 2 | Per-channel correctable flag |
| ch_ue_i | input | 2 | Per-channel uncorrectable flag |
| ce_thresh_i | input | CW | Correctable count threshold |
| ce_clr_i | input | 2**RANK_BITS | Per-rank threshold re-arm |
| ce_cnt_o | output | 2**RANK_BITS*CW | Per-rank correctable counts |
| ce_first_o | output | 1 | First correctable event of a rank |
| ce_thresh_o | output | 1 | Threshold reached on a rank |
| ce_rank_o | output | RANK_BITS | Rank of the last counted event |
| degraded_o | output | 1 | Running on one channel |
| failed_ch_o | output | 1 | Index of the retired channel |
| failover_evt_o | output | 1 | One-shot failover event |

## Verification
The assertions assume that a channel returns exactly one read beat for each read it accepts, and never returns a beat before it has accepted the read. The bench channel model keeps to this: it answers one cycle after acceptance and raises no unsolicited beats. The assertions also assume that `ce_clr_i` is a short pulse. Error flags are injected per channel, and only while a read is in flight, so each response has a known cause.

// File: rtl/mfo_pkg.sv
package mfo_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_RD, S_RDW, S_RT, S_RTW
  } mfo_state_e;
endpackage

// File: rtl/mfo_health.sv
module mfo_health (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fo_i,
  input  logic fo_ch_i,
  output logic degraded_o,
  output logic failed_ch_o,
  output logic evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      degraded_o  <= 1'b0;
      failed_ch_o <= 1'b0;
      evt_o       <= 1'b0;
    end else begin
      evt_o <= fo_i && !degraded_o;
      if (fo_i && !degraded_o) begin
        degraded_o  <= 1'b1;
        failed_ch_o <= fo_ch_i;
      end
    end
  end

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    degraded_o |=> degraded_o && $stable(failed_ch_o));
  p_evt_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> !$past(degraded_o));
endmodule

// File: rtl/mfo_ce_count.sv
module mfo_ce_count #(
  parameter int RB = 2,
  parameter int CW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_i,
  input  logic [RB-1:0]        rank_i,
  input  logic [CW-1:0]        thresh_i,
  input  logic [(1<<RB)-1:0]   clr_i,
  output logic [(1<<RB)*CW-1:0] cnt_o,
  output logic                 first_o,
  output logic                 thr_o,
  output logic [RB-1:0]        rank_o
);
  localparam int NR = 1 << RB;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_nx [NR];
  logic [NR-1:0] seen_w, hit_w;

  for (genvar r = 0; r < NR; r++) begin : g_rank
    logic          sel, seen_q, hit_q;
    logic [CW-1:0] cnt_q;
    assign sel       = ce_i && (rank_i == RB'(r));
    assign cnt_nx[r] = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
    assign seen_w[r] = seen_q;
    assign hit_w[r]  = hit_q;
    assign cnt_o[r*CW +: CW] = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        seen_q <= 1'b0;
        hit_q  <= 1'b0;
      end else begin
        if (sel) begin
          cnt_q  <= cnt_nx[r];
          seen_q <= 1'b1;
        end
        if (sel && cnt_nx[r] >= thresh_i) hit_q <= 1'b1;
        else if (clr_i[r])                hit_q <= 1'b0;
      end
    end

    p_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q == CMAX |=> cnt_q == CMAX);
    p_hit_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_q && !clr_i[r]) |=> hit_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o <= 1'b0;
      thr_o   <= 1'b0;
      rank_o  <= '0;
    end else begin
      first_o <= ce_i && !seen_w[rank_i];
      thr_o   <= ce_i && (cnt_nx[rank_i] >= thresh_i) && !hit_w[rank_i];
      if (ce_i) rank_o <= rank_i;
    end
  end

  p_first_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |-> $past(ce_i));
endmodule

// File: rtl/mfo_seq.sv
module mfo_seq
  import mfo_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic [1:0]    ch_valid_o,
  input  logic [1:0]    ch_ready_i,
  output logic          ch_write_o,
  output logic [AW-1:0] ch_addr_o,
  output logic [DW-1:0] ch_wdata_o,
  input  logic [1:0]    ch_rsp_valid_i,
  input  logic [2*DW-1:0] ch_rdata_i,
  input  logic [1:0]    ch_ce_i,
  input  logic [1:0]    ch_ue_i,
  input  logic          degraded_i,
  input  logic          failed_ch_i,
  output logic          rsp_valid_o,
  output logic          rsp_write_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_ce_o,
  output logic          rsp_ue_o,
  output logic          fo_o,
  output logic          fo_ch_o
);
  mfo_state_e    st_q;
  logic [1:0]    acc_q, acc_nx, en;
  logic          pri, alt;
  logic [DW-1:0] dat_pri, dat_alt;

  assign pri     = degraded_i ? ~failed_ch_i : 1'b0;
  assign alt     = ~pri;
  assign en      = degraded_i ? (2'b01 << pri) : 2'b11;
  assign dat_pri = ch_rdata_i[pri*DW +: DW];
  assign dat_alt = ch_rdata_i[alt*DW +: DW];
  assign acc_nx  = acc_q | (ch_valid_o & ch_ready_i);
  assign req_ready_o = (st_q == S_IDLE);
  assign fo_o    = (st_q == S_RTW) && ch_rsp_valid_i[alt] && !ch_ue_i[alt];
  assign fo_ch_o = pri;

  always_comb begin
    ch_valid_o = '0;
    case (st_q)
      S_WR:    ch_valid_o = en & ~acc_q;
      S_RD:    ch_valid_o[pri] = 1'b1;
      S_RT:    ch_valid_o[alt] = 1'b1;
      default: ch_valid_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      acc_q       <= '0;
      ch_write_o  <= 1'b0;
      ch_addr_o   <= '0;
      ch_wdata_o  <= '0;
      rsp_valid_o <= 1'b0;
      rsp_write_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_ce_o    <= 1'b0;
      rsp_ue_o    <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid_i) begin
          st_q       <= req_write_i ? S_WR : S_RD;
          ch_write_o <= req_write_i;
          ch_addr_o  <= req_addr_i;
          ch_wdata_o <= req_wdata_i;
          acc_q      <= '0;
        end
        S_WR: begin
          acc_q <= acc_nx;
          if ((acc_nx & en) == en) begin
            st_q        <= S_IDLE;
            rsp_valid_o <= 1'b1;
            rsp_write_o <= 1'b1;
            rsp_ce_o    <= 1'b0;
            rsp_ue_o    <= 1'b0;
          end
        end
        S_RD: if (ch_ready_i[pri]) st_q <= S_RDW;
        S_RDW: if (ch_rsp_valid_i[pri]) begin
          if (ch_ue_i[pri] && !degraded_i) begin
            st_q <= S_RT;
          end else begin
            st_q        <= S_IDLE;
            rsp_valid_o <= 1'b1;
            rsp_write_o <= 1'b0;
            rsp_rdata_o <= dat_pri;
            rsp_ce_o    <= ch_ce_i[pri] && !ch_ue_i[pri];
            rsp_ue_o    <= ch_ue_i[pri];
          end
        end
        S_RT: if (ch_ready_i[alt]) st_q <= S_RTW;
        S_RTW: if (ch_rsp_valid_i[alt]) begin
          st_q        <= S_IDLE;
          rsp_valid_o <= 1'b1;
          rsp_write_o <= 1'b0;
          rsp_rdata_o <= dat_alt;
          rsp_ce_o    <= !ch_ue_i[alt];  // recovered error demoted
          rsp_ue_o    <= ch_ue_i[alt];
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_no_dead_ch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    degraded_i |-> !ch_valid_o[failed_ch_i]);
  p_flags_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_ce_o && rsp_ue_o));
  p_ack_both_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WR && !degraded_i && !acc_q[1] && !ch_ready_i[1]) |=> !rsp_valid_o);
endmodule

// File: rtl/mirror_failover.sv
module mirror_failover #(
  parameter int DW        = 64,
  parameter int AW        = 16,
  parameter int RANK_BITS = 2,
  parameter int CW        = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic                          req_write_i,
  input  logic [AW-1:0]                 req_addr_i,
  input  logic [DW-1:0]                 req_wdata_i,
  output logic                          rsp_valid_o,
  output logic                          rsp_write_o,
  output logic [DW-1:0]                 rsp_rdata_o,
  output logic                          rsp_ce_o,
  output logic                          rsp_ue_o,
  output logic [1:0]                    ch_valid_o,
  input  logic [1:0]                    ch_ready_i,
  output logic                          ch_write_o,
  output logic [AW-1:0]                 ch_addr_o,
  output logic [DW-1:0]                 ch_wdata_o,
  input  logic [1:0]                    ch_rsp_valid_i,
  input  logic [2*DW-1:0]               ch_rdata_i,
  input  logic [1:0]                    ch_ce_i,
  input  logic [1:0]                    ch_ue_i,
  input  logic [CW-1:0]                 ce_thresh_i,
  input  logic [(1<<RANK_BITS)-1:0]     ce_clr_i,
  output logic [(1<<RANK_BITS)*CW-1:0]  ce_cnt_o,
  output logic                          ce_first_o,
  output logic                          ce_thresh_o,
  output logic [RANK_BITS-1:0]          ce_rank_o,
  output logic                          degraded_o,
  output logic                          failed_ch_o,
  output logic                          failover_evt_o
);
  logic fo, fo_ch, ce_evt;
  logic [AW-1:0] addr_w;

  mfo_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i, .req_ready_o,
    .ch_valid_o, .ch_ready_i, .ch_write_o, .ch_addr_o(addr_w), .ch_wdata_o,
    .ch_rsp_valid_i, .ch_rdata_i, .ch_ce_i, .ch_ue_i,
    .degraded_i(degraded_o), .failed_ch_i(failed_ch_o),
    .rsp_valid_o, .rsp_write_o, .rsp_rdata_o, .rsp_ce_o, .rsp_ue_o,
    .fo_o(fo), .fo_ch_o(fo_ch)
  );

  mfo_health u_health (
    .clk_i, .rst_ni, .fo_i(fo), .fo_ch_i(fo_ch),
    .degraded_o, .failed_ch_o, .evt_o(failover_evt_o)
  );

  assign ch_addr_o = addr_w;
  assign ce_evt    = rsp_valid_o && !rsp_write_o && rsp_ce_o;

  mfo_ce_count #(.RB(RANK_BITS), .CW(CW)) u_cnt (
    .clk_i, .rst_ni, .ce_i(ce_evt), .rank_i(addr_w[AW-1 -: RANK_BITS]),
    .thresh_i(ce_thresh_i), .clr_i(ce_clr_i), .cnt_o(ce_cnt_o),
    .first_o(ce_first_o), .thr_o(ce_thresh_o), .rank_o(ce_rank_o)
  );

  p_evt_with_rsp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failover_evt_o |-> rsp_valid_o && rsp_ce_o);
endmodule

// File: tb/mirror_failover_test.sv
module mirror_failover_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, AW = 4, RB = 1, CW = 3, NR = 2, DEPTH = 16;

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_write, rsp_ce, rsp_ue;
  logic [DW-1:0] rsp_rdata;
  logic [1:0] ch_valid, ch_ready = 2'b11, ch_rsp_valid = '0, ch_ce = '0, ch_ue = '0;
  logic ch_write;
  logic [AW-1:0] ch_addr;
  logic [DW-1:0] ch_wdata;
  logic [DW-1:0] rd0 = '0, rd1 = '0;
  logic [CW-1:0] thresh = 3'd3;
  logic [NR-1:0] clr = '0;
  logic [NR*CW-1:0] cnt;
  logic first, thr, degraded, failed_ch, evt;
  logic [RB-1:0] rank;

  mirror_failover #(.DW(DW), .AW(AW), .RANK_BITS(RB), .CW(CW)) uut (
    .clk_i(clk), .rst_ni,
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_write_o(rsp_write), .rsp_rdata_o(rsp_rdata),
    .rsp_ce_o(rsp_ce), .rsp_ue_o(rsp_ue),
    .ch_valid_o(ch_valid), .ch_ready_i(ch_ready), .ch_write_o(ch_write),
    .ch_addr_o(ch_addr), .ch_wdata_o(ch_wdata),
    .ch_rsp_valid_i(ch_rsp_valid), .ch_rdata_i({rd1, rd0}),
    .ch_ce_i(ch_ce), .ch_ue_i(ch_ue),
    .ce_thresh_i(thresh), .ce_clr_i(clr), .ce_cnt_o(cnt),
    .ce_first_o(first), .ce_thresh_o(thr), .ce_rank_o(rank),
    .degraded_o(degraded), .failed_ch_o(failed_ch), .failover_evt_o(evt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // channel model
  logic [DW-1:0] mem [2][DEPTH];
  logic [1:0] inj_ce = '0, inj_ue = '0, pend = '0;
  logic [AW-1:0] paddr [2];
  int wcnt [2], rcnt [2];
  initial begin
    for (int c = 0; c < 2; c++) begin
      wcnt[c] = 0; rcnt[c] = 0; paddr[c] = '0;
      for (int a = 0; a < DEPTH; a++) mem[c][a] = '0;
    end
  end
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      ch_rsp_valid[c] = 1'b0;
      if (pend[c]) begin
        ch_rsp_valid[c] = 1'b1;
        ch_ce[c] = inj_ce[c];
        ch_ue[c] = inj_ue[c];
        if (c == 0) rd0 = inj_ue[c] ? ~mem[c][paddr[c]] : mem[c][paddr[c]];
        else        rd1 = inj_ue[c] ? ~mem[c][paddr[c]] : mem[c][paddr[c]];
        pend[c] = 1'b0;
      end
      if (ch_valid[c] && ch_ready[c]) begin
        if (ch_write) begin mem[c][ch_addr] = ch_wdata; wcnt[c]++; end
        else begin pend[c] = 1'b1; paddr[c] = ch_addr; rcnt[c]++; end
      end
    end
  end

  int tests = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] shadow [DEPTH];
  logic g_valid, g_ce, g_ue, g_evt, g_write;
  logic [DW-1:0] g_data;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    g_valid = 0;
    for (int i = 0; i < 50 && !g_valid; i++) begin
      if (rsp_valid) begin
        g_valid = 1; g_ce = rsp_ce; g_ue = rsp_ue; g_evt = evt;
        g_data = rsp_rdata; g_write = rsp_write;
      end else @(negedge clk);
    end
  endtask

  function automatic logic [CW-1:0] cnt_of(input int r);
    return cnt[r*CW +: CW];
  endfunction

  task automatic ce_read(input logic [AW-1:0] a, input string req,
                         input logic [CW-1:0] ecnt, input logic efirst, input logic ethr);
    inj_ce[0] = 1;
    issue(0, a, '0);
    inj_ce[0] = 0;
    check({req, " ce flag"}, {31'd0, g_ce}, 1);
    @(negedge clk);
    check({req, " count"}, cnt_of(a[AW-1]), ecnt);
    check({req, " first"}, first, efirst);
    check({req, " thresh"}, thr, ethr);
    check({req, " rank"}, rank, a[AW-1]);
  endtask

  initial begin
    int w0, w1, r0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 ready", req_ready, 1);
    check("R12 rsp", rsp_valid, 0);
    check("R12 degraded", degraded, 0);
    check("R12 evt", evt, 0);
    check("R12 cnt", cnt, 0);
    rst_ni = 1;
    @(negedge clk);

    // R1 sweep writes to both channels
    for (int a = 0; a < DEPTH; a++) begin
      shadow[a] = DW'(16'h1234 + a * 16'h0101);
      issue(1, AW'(a), shadow[a]);
      check("R1 ack", {g_valid, g_write}, 2'b11);
    end
    check("R1 ch0 writes", wcnt[0], DEPTH);
    check("R1 ch1 writes", wcnt[1], DEPTH);
    for (int a = 0; a < DEPTH; a++) begin
      check("R1 mirror ch0", mem[0][a], shadow[a]);
      check("R1 mirror ch1", mem[1][a], shadow[a]);
    end
    // R1 ack waits for slow channel 1
    ch_ready = 2'b01;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 4'd7; req_wdata = 16'hbeef;
    shadow[7] = 16'hbeef;
    @(negedge clk); req_valid = 0;
    g_valid = 0;
    repeat (6) begin
      @(negedge clk);
      if (rsp_valid) g_valid = 1;
    end
    check("R1 no ack with ch1 stalled", g_valid, 0);
    ch_ready = 2'b11;
    g_valid = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rsp_valid) g_valid = 1;
    end
    check("R1 ack after ch1 accepts", g_valid, 1);
    check("R1 ch1 holds late write", mem[1][7], 16'hbeef);

    // R2 sweep reads from channel 0
    r0 = rcnt[0];
    for (int a = 0; a < DEPTH; a++) begin
      issue(0, AW'(a), '0);
      check("R2 data", g_data, shadow[a]);
      check("R2 flags", {g_valid, g_ce, g_ue}, 3'b100);
    end
    check("R2 ch0 reads", rcnt[0] - r0, DEPTH);
    check("R2 ch1 reads", rcnt[1], 0);

    // R9 R10 R11 counters, rank 0 (addr bit 3 = 0)
    ce_read(4'd2, "R10 first rank0", 3'd1, 1, 0);
    ce_read(4'd2, "R9 rank0 second", 3'd2, 0, 0);
    ce_read(4'd3, "R11 reach thresh", 3'd3, 0, 1);
    ce_read(4'd2, "R11 no repeat", 3'd4, 0, 0);
    @(negedge clk); clr = 2'b01; @(negedge clk); clr = 2'b00;
    ce_read(4'd2, "R11 re-armed", 3'd5, 0, 1);
    check("R9 rank1 untouched", cnt_of(1), 0);
    // rank 1 and saturation
    ce_read(4'd9, "R10 first rank1", 3'd1, 1, 0);
    ce_read(4'd9, "R9 rank1 two", 3'd2, 0, 0);
    ce_read(4'd9, "R11 rank1 thresh", 3'd3, 0, 1);
    for (int k = 4; k <= 7; k++) ce_read(4'd9, "R9 rank1 climb", CW'(k), 0, 0);
    ce_read(4'd9, "R9 saturate", 3'd7, 0, 0);
    ce_read(4'd9, "R9 saturate hold", 3'd7, 0, 0);

    // R7 both channels uncorrectable
    inj_ue = 2'b11;
    issue(0, 4'd4, '0);
    inj_ue = 2'b00;
    check("R7 ue", {g_ce, g_ue}, 2'b01);
    check("R7 no evt", g_evt, 0);
    check("R7 healthy", degraded, 0);
    check("R7 retry used ch1", rcnt[1], 1);

    // R3 R4 R5 failover
    inj_ue = 2'b01;
    issue(0, 4'd5, '0);
    inj_ue = 2'b00;
    check("R3 data from partner", g_data, shadow[5]);
    check("R3 demoted", {g_ce, g_ue}, 2'b10);
    check("R5 evt with rsp", g_evt, 1);
    check("R4 degraded", degraded, 1);
    check("R4 failed ch", failed_ch, 0);
    @(negedge clk);
    check("R5 evt single cycle", evt, 0);
    check("R9 recovered counted", cnt_of(0), 3'd6);

    // R6 survivor only, ch0 not ready
    ch_ready = 2'b10;
    w0 = wcnt[0]; w1 = wcnt[1]; r0 = rcnt[0];
    for (int a = 0; a < DEPTH; a++) begin
      shadow[a] = DW'(16'h8000 ^ (a * 16'h0311));
      issue(1, AW'(a), shadow[a]);
      check("R6 survivor ack", {g_valid, g_write}, 2'b11);
    end
    for (int a = 0; a < DEPTH; a++) begin
      issue(0, AW'(a), '0);
      check("R6 survivor data", g_data, shadow[a]);
    end
    check("R6 ch0 no writes", wcnt[0] - w0, 0);
    check("R6 ch1 writes", wcnt[1] - w1, DEPTH);
    check("R6 ch0 no reads", rcnt[0] - r0, 0);

    // R8 survivor uncorrectable
    inj_ue = 2'b10;
    issue(0, 4'd1, '0);
    inj_ue = 2'b00;
    check("R8 ue passes", {g_valid, g_ce, g_ue}, 3'b101);
    check("R8 no evt", g_evt, 0);
    check("R4 still degraded", {degraded, failed_ch}, 2'b10);

    // R12 reset clears status
    @(negedge clk); rst_ni = 0;
    @(negedge clk);
    check("R12 reset clears degraded", degraded, 0);
    check("R12 reset clears counts", cnt, 0);
    rst_ni = 1;

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule